// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is one stage of a binary counter that steps up or down by one on each rising clock edge. Counting is allowed only while an active-low enable input is low. The stage drives an active-low carry output that goes low at the terminal count of the current direction. Several stages share one clock, and each stage's carry output drives the enable of the stage above it. The lower stage then lets the upper stage step exactly once each time it wraps, so a chain of stages forms a wider counter. The same carry output can serve as a terminal-count flag, for example to reload the chain when it is used as a programmable divider.

A reset input clears the count, and a load input places a parallel value on the count. Both act as soon as they are asserted, with no clock edge, and both stop counting while they are high. Reset takes priority over load, load over the enable, and the enable over the direction.

Internally the inputs are decoded each cycle into one of five operating modes:
- `MODE_CLEAR`: reset is high.
- `MODE_LOAD`: load is high and reset is low.
- `MODE_HOLD`: the enable is high.
- `MODE_UP`: enabled, direction high.
- `MODE_DOWN`: enabled, direction low.

At every rising edge the count register takes the next value for the current mode. A `MODE_UP` step wraps from the top value to zero, and a `MODE_DOWN` step wraps from zero to the top value. The visible count comes from the load value while in `MODE_LOAD` and from the register otherwise. The register clears asynchronously on reset.

Top module: `cascade_counter`

## Requirements
- R1: With reset low, load low, the enable `carry_in_n` low and `count_up` high, each rising clock edge raises `count` by one, and the value 15 steps to 0. Bit 0 of `count` is the least significant bit.
- R2: With reset low, load low, `carry_in_n` low and `count_up` low, each rising clock edge lowers `count` by one, and the value 0 steps to 15.
- R3: While `carry_in_n` is high (and load and reset are low), clock edges leave `count` unchanged.
- R4: Reset high forces `count` to 0 at once, without a clock edge. While reset is high, `count` stays 0 whatever the values of load, `carry_in_n` and `count_up`.
- R5: Load high (with reset low) puts `load_val` on `count` at once, without a clock edge, and it follows `load_val` while load stays high. Clock edges during load do not count. If at least one rising edge occurs while load is high, counting resumes from the loaded value once load falls.
- R6: With `count_up` high, `carry_out_n` is 0 exactly when `count` is 15 and `carry_in_n` is 0. Otherwise it is 1.
- R7: With `count_up` low, `carry_out_n` is 0 exactly when `count` is 0 and `carry_in_n` is 0. Otherwise it is 1.
- R8: `carry_out_n` follows changes of `carry_in_n`, `count_up` and `count` within the same cycle, with no clock edge in between.
- R9: When two stages share the clock and the lower stage's `carry_out_n` drives the upper stage's `carry_in_n`, the pair counts as one 8-bit value {upper, lower}. Going up it passes through 253, 254, 255, 0, 1. Going down it passes through 2, 1, 0, 255, 254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Asynchronous clear, active high, highest priority |
| carry_in_n | input | 1 | Active-low count enable, fed from the lower stage's carry |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| load_en | input | 1 | Asynchronous parallel load, active high |
| load_val | input | WIDTH (4) | Value placed on the count while load is high |
| count | output | WIDTH (4) | Current count, bit 0 least significant |
| carry_out_n | output | 1 | Active-low terminal-count carry to the next stage |

## Verification
A counting step shows on `count` one rising edge after the inputs that select it. The bench changes its inputs 2 ns after an edge and compares the count 2 ns after the following edge, so each check sees exactly one step. The carry output, the load value and the reset clear all take effect with no edge at all. Those checks apply a change partway through a cycle and compare 1 ns later, well before the next edge. The cascade checks compare the combined 8-bit value against a reference counter that the bench advances once per edge.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    // Operating mode selected from the control inputs each cycle
    typedef enum logic [2:0] {
        MODE_CLEAR = 3'd0,
        MODE_LOAD  = 3'd1,
        MODE_HOLD  = 3'd2,
        MODE_UP    = 3'd3,
        MODE_DOWN  = 3'd4
    } ctr_mode_e;

endpackage

// File: rtl/cascade_counter_mode.sv
module cascade_counter_mode
    import cascade_counter_pkg::*;
(
    input  logic      rst,
    input  logic      load_en,
    input  logic      carry_in_n,
    input  logic      count_up,
    output ctr_mode_e mode
);

    // Priority: clear, then load, then enable, then direction
    always_comb begin
        unique casez ({rst, load_en, carry_in_n, count_up})
            4'b1???: mode = MODE_CLEAR;
            4'b01??: mode = MODE_LOAD;
            4'b001?: mode = MODE_HOLD;
            4'b0001: mode = MODE_UP;
            4'b0000: mode = MODE_DOWN;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/cascade_counter_step.sv
module cascade_counter_step
    import cascade_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Modulo arithmetic gives the wrap in both directions
    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = load_val;
            MODE_HOLD:  nxt = cur;
            MODE_UP:    nxt = cur + ONE;
            MODE_DOWN:  nxt = cur - ONE;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/cascade_counter_carry.sv
module cascade_counter_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             count_up,
    input  logic             carry_in_n,
    output logic             carry_out_n
);

    localparam logic [WIDTH-1:0] TOP = '1;

    logic at_end;

    // Terminal value depends on direction; no register on this path
    always_comb begin
        at_end      = count_up ? (cur == TOP) : (cur == '0);
        carry_out_n = ~(at_end & ~carry_in_n);
    end

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             carry_in_n,
    input  logic             count_up,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out_n
);

    ctr_mode_e        mode;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    cascade_counter_mode u_mode (
        .rst        (rst),
        .load_en    (load_en),
        .carry_in_n (carry_in_n),
        .count_up   (count_up),
        .mode       (mode)
    );

    cascade_counter_step #(.WIDTH(WIDTH)) u_step (
        .mode     (mode),
        .cur      (cnt_q),
        .load_val (load_val),
        .nxt      (cnt_d)
    );

    // State register: cleared the moment reset rises
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Output process: a load is visible before any edge
    always_comb begin
        if (mode == MODE_LOAD) begin
            count = load_val;
        end else begin
            count = cnt_q;
        end
    end

    cascade_counter_carry #(.WIDTH(WIDTH)) u_carry (
        .cur         (count),
        .count_up    (count_up),
        .carry_in_n  (carry_in_n),
        .carry_out_n (carry_out_n)
    );

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             carry_in_n,
    input logic             count_up,
    input logic             load_en,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_out_n
);

    localparam logic [WIDTH-1:0] TOP = '1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Set once a full clock edge has passed with reset low
    logic seen;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(!rst && !load_en && !carry_in_n && count_up) && !load_en)
        |-> (count == $past(count) + ONE));

    a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(!rst && !load_en && !carry_in_n && !count_up) && !load_en)
        |-> (count == $past(count) - ONE));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(!rst && !load_en && carry_in_n) && !load_en)
        |-> (count == $past(count)));

    a_r4_clear: assert property (@(negedge clk)
        rst |-> (count == '0));

    a_r5_load_visible: assert property (@(negedge clk) disable iff (rst)
        load_en |-> (count == load_val));

    a_r6_carry_up: assert property (@(negedge clk) disable iff (rst)
        count_up |-> (carry_out_n == !(!carry_in_n && count == TOP)));

    a_r7_carry_down: assert property (@(negedge clk) disable iff (rst)
        !count_up |-> (carry_out_n == !(!carry_in_n && count == '0)));

endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .carry_in_n  (carry_in_n),
    .count_up    (count_up),
    .load_en     (load_en),
    .load_val    (load_val),
    .count       (count),
    .carry_out_n (carry_out_n)
);

// File: tb/test_cascade_counter.sv
module test_cascade_counter;

    logic       clk = 1'b0;
    logic       rst;
    logic       cin_n;
    logic       dir;
    logic       load;
    logic [7:0] pv;
    logic [3:0] lo_q, hi_q;
    logic       lo_co, hi_co;
    logic [7:0] both;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign both = {hi_q, lo_q};

    cascade_counter #(.WIDTH(4)) i_cascade_counter (
        .clk(clk), .rst(rst), .carry_in_n(cin_n), .count_up(dir),
        .load_en(load), .load_val(pv[3:0]), .count(lo_q), .carry_out_n(lo_co)
    );

    cascade_counter #(.WIDTH(4)) i_cascade_counter_msd (
        .clk(clk), .rst(rst), .carry_in_n(lo_co), .count_up(dir),
        .load_en(load), .load_val(pv[7:4]), .count(hi_q), .carry_out_n(hi_co)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic load_value(input logic [7:0] v);
        load = 1'b1;
        pv   = v;
        step();
        load = 1'b0;
    endtask

    task automatic t_reset();
        step();
        step();
        chk("R4 reset low count", 8'(lo_q), 8'd0);
        chk("R4 reset high count", 8'(hi_q), 8'd0);
        chk("R6 carry idle after reset", 8'(lo_co), 8'd1);
        rst = 1'b0;
    endtask

    task automatic t_up_wrap();
        dir = 1'b1; cin_n = 1'b0;
        load_value(8'h0D);
        chk("R5 loaded 13", 8'(lo_q), 8'd13);
        step(); chk("R1 up 14", 8'(lo_q), 8'd14);
        step(); chk("R1 up 15", 8'(lo_q), 8'd15);
        chk("R6 carry low at 15", 8'(lo_co), 8'd0);
        step(); chk("R1 wrap to 0", 8'(lo_q), 8'd0);
        chk("R6 carry high at 0", 8'(lo_co), 8'd1);
        step(); chk("R1 up 1", 8'(lo_q), 8'd1);
    endtask

    task automatic t_down_wrap();
        dir = 1'b0; cin_n = 1'b0;
        load_value(8'h02);
        step(); chk("R2 down 1", 8'(lo_q), 8'd1);
        step(); chk("R2 down 0", 8'(lo_q), 8'd0);
        chk("R7 carry low at 0", 8'(lo_co), 8'd0);
        step(); chk("R2 wrap to 15", 8'(lo_q), 8'd15);
        chk("R7 carry high at 15", 8'(lo_co), 8'd1);
        step(); chk("R2 down 14", 8'(lo_q), 8'd14);
    endtask

    task automatic t_hold();
        dir = 1'b1; cin_n = 1'b0;
        load_value(8'h0F);
        cin_n = 1'b1;
        #1 chk("R6 carry high when disabled", 8'(lo_co), 8'd1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 hold", 8'(lo_q), 8'd15);
        end
        cin_n = 1'b0;
        #1 chk("R8 carry falls without edge", 8'(lo_co), 8'd0);
        step(); chk("R1 resume after hold", 8'(lo_q), 8'd0);
    endtask

    task automatic t_carry_comb();
        dir = 1'b0; cin_n = 1'b0;
        load_value(8'h00);
        #1 chk("R7 carry low at 0 down", 8'(lo_co), 8'd0);
        cin_n = 1'b1;
        #1 chk("R8 carry follows enable", 8'(lo_co), 8'd1);
        cin_n = 1'b0; dir = 1'b1;
        #1 chk("R8 carry follows direction", 8'(lo_co), 8'd1);
        dir = 1'b0;
        #1 chk("R8 carry back low", 8'(lo_co), 8'd0);
    endtask

    task automatic t_preset_async();
        dir = 1'b1; cin_n = 1'b0;
        step();
        #1 load = 1'b1; pv = 8'h09;
        #1 chk("R5 load without edge", 8'(lo_q), 8'd9);
        step(); chk("R5 no count during load", 8'(lo_q), 8'd9);
        pv = 8'h03;
        #1 chk("R5 follows load value", 8'(lo_q), 8'd3);
        step(); chk("R5 still blocked", 8'(lo_q), 8'd3);
        load = 1'b0;
        step(); chk("R5 count resumes from load", 8'(lo_q), 8'd4);
    endtask

    task automatic t_reset_async();
        dir = 1'b1; cin_n = 1'b0;
        load_value(8'h0A);
        #1 rst = 1'b1; load = 1'b1; pv = 8'h05;
        #1 chk("R4 clear without edge over load", 8'(lo_q), 8'd0);
        step(); chk("R4 clear holds at edge", 8'(lo_q), 8'd0);
        rst = 1'b0;
        #1 chk("R5 load after reset release", 8'(lo_q), 8'd5);
        load = 1'b0;
        step(); chk("R1 count from cleared state", 8'(lo_q), 8'd1);
    endtask

    task automatic t_cascade_up();
        logic [7:0] ref_v;
        dir = 1'b1; cin_n = 1'b0;
        load_value(8'd253);
        ref_v = 8'd253;
        chk("R9 cascade start 253", both, ref_v);
        for (int i = 0; i < 4; i++) begin
            step();
            ref_v = ref_v + 8'd1;
            chk("R9 cascade up", both, ref_v);
            if (ref_v == 8'd255) chk("R9 upper carry at 255", 8'(hi_co), 8'd0);
        end
    endtask

    task automatic t_cascade_down();
        logic [7:0] ref_v;
        dir = 1'b0; cin_n = 1'b0;
        load_value(8'd2);
        ref_v = 8'd2;
        chk("R9 cascade start 2", both, ref_v);
        for (int i = 0; i < 4; i++) begin
            step();
            ref_v = ref_v - 8'd1;
            chk("R9 cascade down", both, ref_v);
            if (ref_v == 8'd0) chk("R9 upper carry at 0", 8'(hi_co), 8'd0);
        end
    endtask

    initial begin
        rst = 1'b1; cin_n = 1'b0; dir = 1'b1; load = 1'b0; pv = 8'h00;
        t_reset();
        t_up_wrap();
        t_down_wrap();
        t_hold();
        t_carry_comb();
        t_preset_async();
        t_reset_async();
        t_cascade_up();
        t_cascade_down();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule